// File: doc/BRIEF.md
# Pipelined Bitonic Key Sorter

This block puts 2^DEGREE unsigned keys into ascending order. The keys arrive together on one wide bus. A complete list can enter on every clock, and its sorted version leaves after a fixed number of cycles. Lists that follow one another do not interact.

The network is built by recursion. A sorter for 2^D keys sorts the lower half and the upper half separately, with two sorters of size 2^(D-1). It then reverses the order of the upper half's result, which makes the whole list rise and then fall. A butterfly merger of depth D turns that list into one ascending list. A two-key sorter is a single ascending compare-exchange cell.

The recursion is flattened into D(D+1)/2 comparator columns. Each column applies the same ascending cell to pairs of lanes. A per-column mask chooses which columns end in a pipeline register, so the latency can be traded against clock rate. For example, registering 14 of the 15 columns of a 32-key sorter gives a 14-cycle latency.

Top module: `bitonic_sorter`

## Requirements
- R1: Whenever out_valid is high, out_data is non-decreasing from lane 0 upward under unsigned comparison, so lane 0 holds the smallest key.
- R2: Each output list is a permutation of its input list. A key that appears several times in the input appears the same number of times in the output.
- R3: The network has DEGREE*(DEGREE+1)/2 comparator columns. The latency equals the number of columns whose bit is set in REG_MASK (bit c belongs to column c). With the defaults (DEGREE=3, all bits set) the latency is 6 cycles.
- R4: A new list is accepted on every clock cycle that in_valid is high. Lists entered back to back each come out sorted in their own cycle, in entry order.
- R5: While the synchronous active-high reset is asserted, every list in flight is discarded. out_valid goes low at the first clock edge with reset high, and stays low until a list entered after reset has passed through the pipeline.
- R6: Lists that are already ascending, strictly descending, or made of one repeated key come out in correct ascending order.
- R7: out_valid is low in exactly those cycles where in_valid was low one latency earlier. A gap in the input stream gives a gap of the same length in the output stream.
- R8: Keys are compared as unsigned. The all-ones key (16'hFFFF at the default width) sorts above every other key, and zero sorts below every other key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks in_data as a list to be sorted this cycle |
| in_data | input | 2^DEGREE x WIDTH | Unsorted keys, lane i in element [i] |
| out_valid | output | 1 | Marks out_data as a sorted list |
| out_data | output | 2^DEGREE x WIDTH | Sorted keys, smallest in element [0] |

## Verification
The hardest case to reach from the ports is a reset that arrives while several lists are still partway through the registered columns. Correct behaviour here means none of those lists ever appears at the output. The bench enters a few lists, raises reset before any of them can emerge, and then watches out_valid for longer than a full latency. Precise latency is also checked on back-to-back streams and on streams with gaps. Each output list must appear in the exact cycle its entry time predicts, so an extra or missing register in any column is caught.

// File: rtl/bsort_pkg.sv
package bsort_pkg;

    // Number of comparator columns in a sorter of the given degree.
    function automatic int col_count(input int degree);
        return degree * (degree + 1) / 2;
    endfunction

    // Merge level (1..degree) that column c belongs to.
    function automatic int col_level(input int degree, input int c);
        int idx;
        idx = 0;
        for (int m = 1; m <= degree; m++) begin
            for (int s = m; s >= 1; s--) begin
                if (idx == c) return m;
                idx++;
            end
        end
        return 1;
    endfunction

    // Lane distance between the two inputs of every cell in column c.
    function automatic int col_dist(input int degree, input int c);
        int idx;
        idx = 0;
        for (int m = 1; m <= degree; m++) begin
            for (int s = m; s >= 1; s--) begin
                if (idx == c) return 1 << (s - 1);
                idx++;
            end
        end
        return 1;
    endfunction

    // Number of registered columns among the first n mask bits.
    function automatic int mask_pop(input logic [63:0] mask, input int n);
        int cnt;
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            if (mask[i]) cnt++;
        end
        return cnt;
    endfunction

    typedef enum logic {
        STAGE_COMB = 1'b0,
        STAGE_REG  = 1'b1
    } stage_kind_e;

endpackage

// File: rtl/bsort_cx.sv
module bsort_cx #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi
);
    logic a_first;

    assign a_first = (a <= b);
    assign lo      = a_first ? a : b;
    assign hi      = a_first ? b : a;
endmodule

// File: rtl/bsort_column.sv
module bsort_column #(
    parameter int                   N    = 8,
    parameter int                   W    = 16,
    parameter int                   BLK  = 2,
    parameter int                   DIST = 1,
    parameter bit                   REV  = 1'b0,
    parameter bsort_pkg::stage_kind_e KIND = bsort_pkg::STAGE_REG
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_v,
    input  logic [N-1:0][W-1:0] in_d,
    output logic                out_v,
    output logic [N-1:0][W-1:0] out_d
);
    localparam int HALF = BLK / 2;

    logic [N-1:0][W-1:0] perm;
    logic [N-1:0][W-1:0] swapped;

    // Optional reversal of the upper half of every block (merge entry).
    always_comb begin
        for (int i = 0; i < N; i++) begin
            int off;
            int base;
            off  = i % BLK;
            base = i - off;
            if (REV && (off >= HALF)) begin
                perm[i] = in_d[base + BLK - 1 + HALF - off];
            end else begin
                perm[i] = in_d[i];
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_lane
        if ((g & DIST) == 0) begin : g_cell
            bsort_cx #(.W(W)) u_cx (
                .a (perm[g]),
                .b (perm[g + DIST]),
                .lo(swapped[g]),
                .hi(swapped[g + DIST])
            );
        end
    end

    if (KIND == bsort_pkg::STAGE_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                out_v <= 1'b0;
                out_d <= '0;
            end else begin
                out_v <= in_v;
                out_d <= swapped;
            end
        end
    end else begin : g_comb
        assign out_v = in_v;
        assign out_d = swapped;
    end
endmodule

// File: rtl/bitonic_sorter.sv
module bitonic_sorter #(
    parameter int          DEGREE   = 3,
    parameter int          WIDTH    = 16,
    parameter logic [63:0] REG_MASK = 64'hFFFF_FFFF_FFFF_FFFF
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 in_valid,
    input  logic [(1<<DEGREE)-1:0][WIDTH-1:0]    in_data,
    output logic                                 out_valid,
    output logic [(1<<DEGREE)-1:0][WIDTH-1:0]    out_data
);
    localparam int N       = 1 << DEGREE;
    localparam int NCOL    = bsort_pkg::col_count(DEGREE);
    localparam int LATENCY = bsort_pkg::mask_pop(REG_MASK, NCOL);

    logic [N-1:0][WIDTH-1:0] col_d [NCOL+1];
    logic                    col_v [NCOL+1];

    assign col_d[0] = in_data;
    assign col_v[0] = in_valid;

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        localparam int LVL = bsort_pkg::col_level(DEGREE, c);
        localparam int DST = bsort_pkg::col_dist(DEGREE, c);
        localparam int BLK = 1 << LVL;
        localparam bit REV = (LVL > 1) && (DST == BLK / 2);
        localparam bsort_pkg::stage_kind_e KIND =
            REG_MASK[c] ? bsort_pkg::STAGE_REG : bsort_pkg::STAGE_COMB;

        bsort_column #(
            .N   (N),
            .W   (WIDTH),
            .BLK (BLK),
            .DIST(DST),
            .REV (REV),
            .KIND(KIND)
        ) u_column (
            .clk  (clk),
            .rst  (rst),
            .in_v (col_v[c]),
            .in_d (col_d[c]),
            .out_v(col_v[c+1]),
            .out_d(col_d[c+1])
        );
    end

    assign out_valid = col_v[NCOL];
    assign out_data  = col_d[NCOL];
endmodule

// File: rtl/bsort_chk.sv
module bsort_chk #(
    parameter int N   = 8,
    parameter int W   = 16,
    parameter int LAT = 6
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [N-1:0][W-1:0] in_data,
    input logic                out_valid,
    input logic [N-1:0][W-1:0] out_data
);
    localparam int SW = W + $clog2(N) + 1;

    function automatic logic [SW-1:0] list_sum(input logic [N-1:0][W-1:0] d);
        logic [SW-1:0] s;
        s = '0;
        for (int i = 0; i < N; i++) s = s + SW'(d[i]);
        return s;
    endfunction

    for (genvar i = 0; i < N - 1; i++) begin : g_order
        p_sorted_r1: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (out_data[i] <= out_data[i+1]));
    end

    if (LAT > 0) begin : g_timed
        logic          vpipe [LAT];
        logic [SW-1:0] spipe [LAT];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int k = 0; k < LAT; k++) begin
                    vpipe[k] <= 1'b0;
                    spipe[k] <= '0;
                end
            end else begin
                vpipe[0] <= in_valid;
                spipe[0] <= list_sum(in_data);
                for (int k = 1; k < LAT; k++) begin
                    vpipe[k] <= vpipe[k-1];
                    spipe[k] <= spipe[k-1];
                end
            end
        end

        // R3 and R7: valid follows input valid by the configured latency
        p_latency_r3: assert property (@(posedge clk) disable iff (rst)
            out_valid == vpipe[LAT-1]);

        p_sum_r2: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (list_sum(out_data) == spipe[LAT-1]));

        p_reset_r5: assert property (@(posedge clk)
            rst |=> !out_valid);
    end
endmodule

bind bitonic_sorter bsort_chk #(
    .N  (1 << DEGREE),
    .W  (WIDTH),
    .LAT(bsort_pkg::mask_pop(REG_MASK, bsort_pkg::col_count(DEGREE)))
) u_bsort_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_data (out_data)
);

// File: tb/tb_bitonic_sorter.sv
module tb_bitonic_sorter;
    localparam int CLK_PERIOD = 10;
    localparam int DEG = 3;
    localparam int W   = 16;
    localparam int N   = 1 << DEG;
    localparam int LAT = DEG * (DEG + 1) / 2;   // R3: all columns registered

    typedef logic [N-1:0][W-1:0] list_t;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  in_valid = 1'b0;
    list_t in_data = '0;
    logic  out_valid;
    list_t out_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    list_t exp_q[$];
    int    due_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bitonic_sorter #(.DEGREE(DEG), .WIDTH(W)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic list_t sort_list(input list_t x);
        list_t y;
        y = x;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N - 1 - i; j++) begin
                if (y[j] > y[j+1]) begin
                    logic [W-1:0] t;
                    t = y[j]; y[j] = y[j+1]; y[j+1] = t;
                end
            end
        end
        return y;
    endfunction

    task automatic note(input bit ok, input string tag, input string what,
                        input list_t act, input list_t exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic note_bit(input bit ok, input string tag, input string what,
                            input logic act, input logic exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // Output monitor: compares every emerging list and its timing.
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (due_q.size() == 0) begin
                    note_bit(1'b0, "R7", "valid with nothing in flight", out_valid, 1'b0);
                end else begin
                    note_bit(due_q[0] == cyc, "R3", "list emerged off its cycle", 1'b1,
                             due_q[0] == cyc);
                    note(out_data == exp_q[0], tag_q[0], "sorted list", out_data, exp_q[0]);
                    void'(exp_q.pop_front());
                    void'(due_q.pop_front());
                    void'(tag_q.pop_front());
                end
            end else if (due_q.size() > 0 && due_q[0] == cyc) begin
                note_bit(1'b0, "R3", "expected list missing", out_valid, 1'b1);
                void'(exp_q.pop_front());
                void'(due_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
    end

    task automatic send(input list_t l, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = l;
        exp_q.push_back(sort_list(l));
        due_q.push_back(cyc + LAT);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = list_t'({$urandom, $urandom, $urandom, $urandom});
        end
    endtask

    task automatic drain(input string tag);
        idle(LAT + 2);
        note_bit(due_q.size() == 0, tag, "lists left undelivered", due_q.size() == 0, 1'b1);
    endtask

    function automatic list_t rand_list(input int span);
        list_t l;
        for (int i = 0; i < N; i++) l[i] = W'($urandom % span);
        return l;
    endfunction

    task automatic t_reset_idle();
        rst = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = rand_list(65536);
            note_bit(out_valid == 1'b0, "R5", "valid during reset", out_valid, 1'b0);
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b0;
        for (int k = 0; k < LAT + 2; k++) begin
            @(negedge clk);
            note_bit(out_valid == 1'b0, "R5", "valid after reset with idle input", out_valid, 1'b0);
        end
    endtask

    task automatic t_shapes();
        list_t l;
        for (int i = 0; i < N; i++) l[i] = W'(i * 3 + 1);
        send(l, "R6");
        for (int i = 0; i < N; i++) l[i] = W'(1000 - i * 7);
        send(l, "R6");
        for (int i = 0; i < N; i++) l[i] = 16'h0A5A;
        send(l, "R6");
        send(rand_list(4), "R2");
        send(rand_list(65536), "R1");
        drain("R6");
    endtask

    task automatic t_extremes();
        list_t l;
        for (int i = 0; i < N; i++) l[i] = (i % 2 == 0) ? 16'hFFFF : 16'h0000;
        send(l, "R8");
        for (int i = 0; i < N; i++) l[i] = (i == 0) ? 16'hFFFF : W'(16'h8000 + i);
        send(l, "R8");
        for (int i = 0; i < N; i++) l[i] = (i == N - 1) ? 16'h0000 : 16'h7FFF;
        send(l, "R8");
        drain("R8");
    endtask

    task automatic t_back_to_back();
        for (int k = 0; k < 40; k++) send(rand_list(65536), "R4");
        for (int k = 0; k < 10; k++) send(rand_list(3), "R2");
        drain("R4");
    endtask

    task automatic t_gaps();
        for (int k = 0; k < 12; k++) begin
            send(rand_list(65536), "R7");
            idle(k % 3);
        end
        drain("R7");
    endtask

    task automatic t_reset_flush();
        for (int k = 0; k < 3; k++) send(rand_list(65536), "R5");
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        exp_q.delete();
        due_q.delete();
        tag_q.delete();
        @(negedge clk);
        note_bit(out_valid == 1'b0, "R5", "valid one edge into reset", out_valid, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < LAT + 3; k++) begin
            @(negedge clk);
            note_bit(out_valid == 1'b0, "R5", "flushed list reappeared", out_valid, 1'b0);
        end
        send(rand_list(65536), "R5");
        drain("R5");
    endtask

    initial begin
        t_reset_idle();
        t_shapes();
        t_extremes();
        t_back_to_back();
        t_gaps();
        t_reset_flush();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule